// File: doc/BRIEF.md
# Descriptor Dispatcher with Parked Replay

This block holds a small queue of transfer descriptors and hands them, one at a time and in arrival order, to a data mover. A host writes a whole descriptor (start address, byte length and a park flag) in a single cycle on a valid/ready push port. The head of the queue is offered on a valid/ready command port. After the mover accepts it, the dispatcher waits for a one-cycle completion pulse before it offers anything else.

When a transfer finishes and the descriptor behind it had its park flag set and no other descriptor is waiting, the head entry is kept and offered again. The mover therefore repeats the same transfer for as long as nothing newer arrives. A newer descriptor takes over only at a transfer boundary. Parked descriptors never alternate: each one repeats until a successor is written.

A stop input holds back new commands. A transfer already in flight still runs to completion. Status outputs report activity, the queue fill level, and the empty and full conditions.

Top module: `desc_dispatch`

## Requirements
- R1: After reset the block is idle: `busy`=0, `cmd_valid`=0, `q_empty`=1, `q_full`=0, `q_level`=0.
- R2: Descriptors are offered on the command port strictly in the order in which they were pushed, each carrying its own address and length.
- R3: After a command is accepted (`cmd_valid` and `cmd_ready` both high at a clock edge), `cmd_valid` stays low until a `xfer_done` pulse has been seen.
- R4: When a transfer completes and its park flag was 0, the descriptor is removed from the queue. If the queue is then empty, `busy` drops to 0 in the cycle after the pulse.
- R5: When a transfer completes, its park flag was 1 and no other descriptor is queued (and none is pushed in the same cycle), the descriptor stays in the queue and is offered again with the same address and length.
- R6: If a descriptor is pushed while a parked descriptor is replaying, the parked one is removed at the next completion and the new one is offered next. With two parked descriptors the first repeats until the second arrives, then only the second repeats.
- R7: `push_ready` is 0 exactly when `q_level` equals DEPTH. A push offered while `push_ready` is 0 is dropped and never offered on the command port.
- R8: While `stop` is high, no new command is raised. A command already accepted still waits for its completion, and the queue contents are kept.
- R9: `q_level` counts the stored descriptors, `q_empty` is high when it is 0 and `q_full` when it is DEPTH. `cmd_valid` is never high while the queue is empty.
- R10: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_addr` and `cmd_len` stay unchanged.
- R11: A `xfer_done` pulse while no command is accepted and outstanding is ignored: it neither removes nor repeats a descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Host offers a descriptor |
| push_addr | input | ADDR_W | Descriptor start address |
| push_len | input | LEN_W | Descriptor byte length |
| push_park | input | 1 | Replay this descriptor when nothing follows it |
| push_ready | output | 1 | A queue entry is free |
| cmd_valid | output | 1 | Head descriptor offered to the mover |
| cmd_ready | input | 1 | Mover accepts the command |
| cmd_addr | output | ADDR_W | Offered address |
| cmd_len | output | LEN_W | Offered length |
| xfer_done | input | 1 | One-cycle pulse: accepted transfer finished |
| stop | input | 1 | Hold back further commands |
| busy | output | 1 | A command is offered or outstanding |
| q_empty | output | 1 | Queue holds no descriptor |
| q_full | output | 1 | Queue holds DEPTH descriptors |
| q_level | output | $clog2(DEPTH+1) | Number of stored descriptors |

## Verification
The hardest case to reach from the ports is the hand-over from one parked descriptor to the next. The second descriptor has to be pushed while the first is outstanding and replaying, and the completion pulse then has to land with two entries queued. The bench accepts the parked command and, before pulsing completion, pushes the second descriptor in the wait window. It does the same with `stop` raised inside the window, to show that the block halts at the boundary and later resumes with the kept parked entry ahead of the newer one.

// File: rtl/desc_dispatch.sv
module desc_dispatch #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [LEN_W-1:0]  push_len,
  input  logic              push_park,
  output logic              push_ready,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  input  logic              xfer_done,
  input  logic              stop,
  output logic              busy,
  output logic              q_empty,
  output logic              q_full,
  output logic [CNT_W-1:0]  q_level
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_t;

  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  state_t            state;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [LEN_W-1:0]  len_q  [DEPTH];
  logic [DEPTH-1:0]  park_q;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;

  logic push_fire, accept, done_fire, keep_head, pop;

  assign push_ready = (count != FULL_LVL);
  assign push_fire  = push_valid && push_ready;
  assign accept     = (state == S_ISSUE) && cmd_ready;
  assign done_fire  = (state == S_WAIT) && xfer_done;
  assign keep_head  = park_q[rd_ptr] && (count == CNT_W'(1)) && !push_fire;
  assign pop        = done_fire && !keep_head;

  assign cmd_valid = (state == S_ISSUE);
  assign cmd_addr  = addr_q[rd_ptr];
  assign cmd_len   = len_q[rd_ptr];
  assign busy      = (state != S_IDLE);
  assign q_level   = count;
  assign q_empty   = (count == '0);
  assign q_full    = (count == FULL_LVL);

  always_ff @(posedge clk) begin
    if (push_fire) begin
      addr_q[wr_ptr] <= push_addr;
      len_q[wr_ptr]  <= push_len;
      park_q[wr_ptr] <= push_park;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_fire) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop)       rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({push_fire, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:  if (count != '0 && !stop) state <= S_ISSUE;
        S_ISSUE: if (cmd_ready) state <= S_WAIT;
        S_WAIT:  if (xfer_done) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len));

  assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cmd_valid);

  assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= FULL_LVL);

  assert_empty_no_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty |-> !cmd_valid);

  assert_stop_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && stop |=> !cmd_valid);

  assert_park_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_fire && keep_head |=> q_level == CNT_W'(1));

endmodule

// File: tb/desc_dispatch_tb_top.sv
`timescale 1ns/1ps
module desc_dispatch_tb_top;
  localparam int AW = 16, LW = 8, DEPTH = 4, CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic push_valid = 0, push_park = 0, cmd_ready = 0, xfer_done = 0, stop = 0;
  logic [AW-1:0] push_addr = '0;
  logic [LW-1:0] push_len = '0;
  logic push_ready, cmd_valid, busy, q_empty, q_full;
  logic [AW-1:0] cmd_addr;
  logic [LW-1:0] cmd_len;
  logic [CW-1:0] q_level;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  desc_dispatch #(.ADDR_W(AW), .LEN_W(LW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_addr(push_addr),
    .push_len(push_len), .push_park(push_park), .push_ready(push_ready),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .xfer_done(xfer_done), .stop(stop), .busy(busy),
    .q_empty(q_empty), .q_full(q_full), .q_level(q_level));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input int a, input int l, input bit p);
    push_valid = 1; push_addr = AW'(a); push_len = LW'(l); push_park = p;
    @(negedge clk);
    push_valid = 0;
  endtask

  task automatic take_cmd(input int a, input int l, input string req, input int d);
    int n = 0;
    while (!cmd_valid && n < 40) begin @(negedge clk); n++; end
    chk(cmd_valid, req, cmd_valid, 1);
    chk(int'(cmd_addr) == a, req, cmd_addr, a);
    chk(int'(cmd_len) == l, req, cmd_len, l);
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      chk(cmd_valid && int'(cmd_addr) == a && int'(cmd_len) == l, "R10", cmd_addr, a);
    end
    cmd_ready = 1;
    @(negedge clk);
    cmd_ready = 0;
  endtask

  task automatic finish_xfer(input int w);
    for (int i = 0; i < w; i++) begin
      chk(!cmd_valid, "R3", cmd_valid, 0);
      @(negedge clk);
    end
    xfer_done = 1;
    @(negedge clk);
    xfer_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !cmd_valid && q_empty && !q_full && q_level == 0, "R1", q_level, 0);

    // R2 R4 R9 R10 sweep: n descriptors, ready delay d
    for (int n = 1; n <= DEPTH; n++) begin
      for (int d = 0; d < 3; d++) begin
        stop = 1;
        for (int i = 0; i < n; i++) begin
          push(n * 256 + i * 16 + d, i + 1 + d, 0);
          chk(q_level == CW'(i + 1) && !q_empty, "R9", q_level, i + 1);
        end
        chk(q_full == (n == DEPTH) && push_ready == (n != DEPTH), "R7", q_full, n == DEPTH);
        stop = 0;
        for (int i = 0; i < n; i++) begin
          take_cmd(n * 256 + i * 16 + d, i + 1 + d, "R2", d);
          finish_xfer(i % 3);
        end
        chk(q_level == 0 && q_empty && !busy, "R4", q_level, 0);
      end
    end

    // R5 R6: parked replay and hand-over
    push(16'h0A00, 8'h11, 1);
    take_cmd(16'h0A00, 8'h11, "R5", 0); finish_xfer(1);
    chk(q_level == 1, "R5", q_level, 1);
    take_cmd(16'h0A00, 8'h11, "R5", 1); finish_xfer(0);
    take_cmd(16'h0A00, 8'h11, "R6", 0);
    push(16'h0B00, 8'h22, 1);
    finish_xfer(1);
    chk(q_level == 1, "R6", q_level, 1);
    take_cmd(16'h0B00, 8'h22, "R6", 0); finish_xfer(2);
    take_cmd(16'h0B00, 8'h22, "R6", 0); finish_xfer(0);

    // R8: stop inside the wait window
    take_cmd(16'h0B00, 8'h22, "R8", 0);
    stop = 1;
    finish_xfer(2);
    repeat (5) @(negedge clk);
    chk(!cmd_valid && !busy && q_level == 1, "R8", cmd_valid, 0);
    push(16'h0C00, 8'h33, 0);
    chk(q_level == 2 && !cmd_valid, "R8", q_level, 2);
    stop = 0;
    take_cmd(16'h0B00, 8'h22, "R2", 0); finish_xfer(0);
    take_cmd(16'h0C00, 8'h33, "R2", 0); finish_xfer(0);
    chk(q_empty && !busy, "R4", q_level, 0);

    // R7: overflow push dropped
    stop = 1;
    for (int i = 0; i <= DEPTH; i++) push(16'h1000 + i, i + 5, 0);
    chk(q_level == CW'(DEPTH) && q_full && !push_ready, "R7", q_level, DEPTH);
    stop = 0;
    for (int i = 0; i < DEPTH; i++) begin
      take_cmd(16'h1000 + i, i + 5, "R7", 0); finish_xfer(1);
    end
    repeat (4) @(negedge clk);
    chk(!cmd_valid && q_empty && !busy, "R7", cmd_valid, 0);

    // R11: stray completion pulses
    xfer_done = 1; @(negedge clk); xfer_done = 0;
    @(negedge clk);
    chk(q_level == 0 && !busy, "R11", q_level, 0);
    push(16'h2000, 8'h44, 0);
    @(negedge clk); @(negedge clk);
    chk(cmd_valid, "R11", cmd_valid, 1);
    xfer_done = 1; @(negedge clk); xfer_done = 0;
    chk(cmd_valid && q_level == 1, "R11", q_level, 1);
    take_cmd(16'h2000, 8'h44, "R11", 0); finish_xfer(1);
    chk(q_empty && !busy, "R11", q_level, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule